// File: doc/BRIEF.md
# FIFO-Framed SPI Transmit Master

This block is the transmit half of an SPI master. The host pushes 8-bit words into a four-entry queue through a plain write port. A shift engine pulls each word from the queue and sends it most significant bit first in SPI mode 0. The serial clock comes from a programmable divider of the system clock, and it runs only while a word is being shifted.

The slave-select line has no per-word framing and no software control. It is driven low only while the queue or the shifter holds data. Words that the host writes faster than one word time go out back to back, so they form a single longer frame. If the host falls behind, select rises between words, even in the middle of a logical message.

A five-bit status word reports:
- queue empty;
- a sticky word-complete flag;
- a sticky frame-complete flag;
- bus idle, which includes a guard time after select rises;
- a sticky overflow flag.

A status-read strobe clears the sticky flags.

Top module: `spi_autoselect_tx`

## Requirements
- R1: `sel_n` is high until at least one word has been written. It goes low on the clock edge after the engine takes a word from the queue, and it stays low while the queue or the shifter holds data.
- R2: If a new word is waiting in the queue when the last bit of the current word ends, that word starts at once. There is no high pulse on `sel_n`, so two quickly written bytes appear on the wire as one 16-bit frame.
- R3: When the last bit ends and the queue is empty, `sel_n` goes high. A word written later opens a new frame, so a slow host produces one frame per word.
- R4: Bits are sent MSB first in mode 0. `sclk` idles low, `mosi` changes only together with a falling edge of `sclk` (or when a word is loaded), and `mosi` is stable while `sclk` is high.
- R5: Each high and low phase of `sclk` lasts `div_val` system clocks. A `div_val` of 0 is treated as 1.
- R6: `sclk` never toggles and stays low while `sel_n` is high.
- R7: The queue holds 4 words, and `full` is high when it holds 4. A write while full is dropped and never reaches the wire.
- R8: status bit 4 (overflow) sets on a write attempt while `full` is high. It stays set until `stat_rd` is pulsed.
- R9: status bit 0 (queue empty) is high whenever the queue holds no word. It goes high in the cycle the last queued word moves into the shifter, while `sel_n` is still low.
- R10: status bit 1 (word done) sets when a word's last bit ends. Status bit 2 (frame done) sets when `sel_n` goes high. A `stat_rd` pulse clears both.
- R11: status bit 3 (idle) goes high exactly 2×`div_val` system clocks after `sel_n` rises, when no word is pending. It is low whenever `sel_n` is low.
- R12: After reset, `sel_n`=1, `sclk`=0, `full`=0 and status is 5'b01001 (empty and idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | DATA_W | Word to send |
| full | output | 1 | Queue holds DEPTH words |
| div_val | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| status | output | 5 | {overflow, idle, frame done, word done, queue empty} |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| sel_n | output | 1 | Active-low slave select |

## Verification
A wrong word or bit count in the engine shows up at the ports within one frame, as the wrong number of rising `sclk` edges or a wrong captured bit pattern. A stale queue pointer or count shows as a duplicated or missing byte on `mosi`, or as `full` rising at the wrong write. A bad select or guard state is seen as a split or merged frame, or as a shift in when idle rises, and that error appears within 2×`div_val` cycles of the frame end.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_SHIFT = 2'd1,
      ENG_GUARD = 2'd2
   } eng_state_t;

   localparam int ST_W     = 5;
   localparam int ST_EMPTY = 0;
   localparam int ST_BYTE  = 1;
   localparam int ST_XFER  = 2;
   localparam int ST_IDLE  = 3;
   localparam int ST_OVF   = 4;
endpackage

// File: rtl/spi_txq.sv
module spi_txq #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic              empty,
   output logic              full
);
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = AW + 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr;
   logic [CNT_W-1:0]  cnt;
   logic              push_ok, pop_ok;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign pop_data = mem[rptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           mem[i] <= '0;
         else if (push_ok && wptr == AW'(i))   mem[i] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push_ok) wptr <= wptr + AW'(1);
         if (pop_ok)  rptr <= rptr + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assert_full_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);
   assert_pop_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_data,
   output logic              q_pop,
   output logic              sclk,
   output logic              mosi,
   output logic              sel_n,
   output logic              byte_end,
   output logic              frame_end,
   output logic              eng_idle
);
   localparam int BIT_W = $clog2(DATA_W);
   localparam int GRD_W = DIV_W + 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   eng_state_t        st;
   logic [DIV_W-1:0]  half, dcnt;
   logic [GRD_W-1:0]  gcnt, glimit;
   logic [BIT_W-1:0]  bcnt;
   logic [DATA_W-1:0] shreg;
   logic              sclk_q, tick, last_fall, start;

   assign half      = (div_val == '0) ? DIV_W'(1) : div_val;
   assign glimit    = ({1'b0, half} << 1) - GRD_W'(1);
   assign tick      = (st == ENG_SHIFT) && (dcnt == half - DIV_W'(1));
   assign last_fall = tick && sclk_q && (bcnt == LAST_BIT);
   assign start     = !q_empty && (st != ENG_SHIFT);
   assign q_pop     = start || (last_fall && !q_empty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ENG_IDLE;
         dcnt   <= '0;
         gcnt   <= '0;
         bcnt   <= '0;
         shreg  <= '0;
         sclk_q <= 1'b0;
      end else begin
         case (st)
            ENG_SHIFT: begin
               if (tick) begin
                  dcnt <= '0;
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (bcnt == LAST_BIT) begin
                        bcnt <= '0;
                        if (!q_empty) begin
                           shreg <= q_data;
                        end else begin
                           st   <= ENG_GUARD;
                           gcnt <= '0;
                        end
                     end else begin
                        bcnt  <= bcnt + BIT_W'(1);
                        shreg <= shreg << 1;
                     end
                  end
               end else begin
                  dcnt <= dcnt + DIV_W'(1);
               end
            end
            default: begin
               if (start) begin
                  st     <= ENG_SHIFT;
                  shreg  <= q_data;
                  bcnt   <= '0;
                  dcnt   <= '0;
                  sclk_q <= 1'b0;
               end else if (st == ENG_GUARD) begin
                  if (gcnt == glimit) st <= ENG_IDLE;
                  else                gcnt <= gcnt + GRD_W'(1);
               end
            end
         endcase
      end
   end

   assign sclk      = sclk_q;
   assign mosi      = shreg[DATA_W-1];
   assign sel_n     = (st != ENG_SHIFT);
   assign byte_end  = last_fall;
   assign frame_end = last_fall && q_empty;
   assign eng_idle  = (st == ENG_IDLE);

   assert_sclk_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |-> !sclk);
   assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));
   assert_select_needs_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_n) |-> $past(!q_empty));
endmodule

// File: rtl/spi_tx_flags.sv
module spi_tx_flags
   import spi_tx_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ovf_evt,
   input  logic            byte_end,
   input  logic            frame_end,
   input  logic            stat_rd,
   input  logic            q_empty,
   input  logic            eng_idle,
   output logic [ST_W-1:0] status
);
   logic ovf_q, byte_q, xfer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q  <= 1'b0;
         byte_q <= 1'b0;
         xfer_q <= 1'b0;
      end else begin
         if (ovf_evt)        ovf_q  <= 1'b1;
         else if (stat_rd)   ovf_q  <= 1'b0;
         if (byte_end)       byte_q <= 1'b1;
         else if (stat_rd)   byte_q <= 1'b0;
         if (frame_end)      xfer_q <= 1'b1;
         else if (stat_rd)   xfer_q <= 1'b0;
      end
   end

   always_comb begin
      status           = '0;
      status[ST_EMPTY] = q_empty;
      status[ST_BYTE]  = byte_q;
      status[ST_XFER]  = xfer_q;
      status[ST_IDLE]  = eng_idle && q_empty;
      status[ST_OVF]   = ovf_q;
   end

   assert_overflow_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> status[ST_OVF]);
   assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !byte_end) |=> !status[ST_BYTE]);
endmodule

// File: rtl/spi_autoselect_tx.sv
module spi_autoselect_tx
   import spi_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              stat_rd,
   output logic [ST_W-1:0]   status,
   output logic              sclk,
   output logic              mosi,
   output logic              sel_n
);
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic              q_pop, q_empty;
   logic [DATA_W-1:0] q_data;
   logic              byte_end, frame_end, eng_idle;

   spi_txq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_en),
      .push_data (wr_data),
      .pop       (q_pop),
      .pop_data  (q_data),
      .empty     (q_empty),
      .full      (full)
   );

   spi_shift_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_val   (div_val),
      .q_empty   (q_empty),
      .q_data    (q_data),
      .q_pop     (q_pop),
      .sclk      (sclk),
      .mosi      (mosi),
      .sel_n     (sel_n),
      .byte_end  (byte_end),
      .frame_end (frame_end),
      .eng_idle  (eng_idle)
   );

   spi_tx_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ovf_evt   (wr_en && full),
      .byte_end  (byte_end),
      .frame_end (frame_end),
      .stat_rd   (stat_rd),
      .q_empty   (q_empty),
      .eng_idle  (eng_idle),
      .status    (status)
   );

   assert_idle_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_IDLE] |-> sel_n);
   assert_frame_done_on_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n) |-> status[ST_XFER]);
endmodule

// File: tb/tb_spi_autoselect_tx.sv
module tb_spi_autoselect_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       full;
   logic [7:0] div_val = 8'd1;
   logic       stat_rd = 1'b0;
   logic [4:0] status;
   logic       sclk, mosi, sel_n;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   spi_autoselect_tx dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
      .div_val(div_val), .stat_rd(stat_rd), .status(status),
      .sclk(sclk), .mosi(mosi), .sel_n(sel_n)
   );

   // wire monitor, sampled on falling system clock edges
   logic [63:0] cap = '0;
   int nbits = 0, frames = 0, half_err = 0, mode_err = 0, gate_err = 0, guard_cnt = 0;
   int exp_half = 1, ph_cnt = 1;
   logic p_sclk = 1'b0, p_sel = 1'b1, p_mosi = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!p_sclk && sclk) begin
            cap   <= {cap[62:0], mosi};
            nbits <= nbits + 1;
         end
         if (p_sel && !sel_n) begin
            frames <= frames + 1;
            ph_cnt <= 1;
         end else if (p_sclk != sclk) begin
            if (ph_cnt != exp_half) half_err <= half_err + 1;
            ph_cnt <= 1;
         end else begin
            ph_cnt <= ph_cnt + 1;
         end
         if (p_sclk && sclk && (mosi != p_mosi)) mode_err <= mode_err + 1;
         if (sel_n && sclk) gate_err <= gate_err + 1;
         if (sel_n && !status[3]) guard_cnt <= guard_cnt + 1;
      end
      p_sclk <= sclk;
      p_sel  <= sel_n;
      p_mosi <= mosi;
   end

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put(logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic put_two(logic [7:0] a, logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_data = a;
      @(negedge clk);
      wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!status[3]) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic read_status();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   // {gap, div, first byte, second byte}
   localparam logic [24:0] VEC [5] = '{
      {1'b0, 8'd1, 8'hA5, 8'h3C},
      {1'b1, 8'd3, 8'hF0, 8'h0F},
      {1'b0, 8'd0, 8'h81, 8'h7E},
      {1'b1, 8'd2, 8'h00, 8'hFF},
      {1'b0, 8'd5, 8'hC3, 8'h96}
   };

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int b_frames, b_bits, b_half, b_mode, b_gate, b_guard, d;
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12", "sel_n", 64'(sel_n), 64'd1);
      check("R12", "sclk", 64'(sclk), 64'd0);
      check("R12", "full", 64'(full), 64'd0);
      check("R12", "status", 64'(status), 64'h09);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      foreach (VEC[i]) begin
         div_val  = VEC[i][23:16];
         d        = (div_val == 0) ? 1 : int'(div_val);
         exp_half = d;
         b_frames = frames; b_bits = nbits; b_half = half_err;
         b_mode = mode_err; b_gate = gate_err; b_guard = guard_cnt;
         if (VEC[i][24]) begin
            put(VEC[i][15:8]);
            wait_idle();
            put(VEC[i][7:0]);
         end else begin
            put_two(VEC[i][15:8], VEC[i][7:0]);
         end
         wait_idle();
         // R2 merged frame / R3 split frame
         check(VEC[i][24] ? "R3" : "R2", "frame count",
               64'(frames - b_frames), VEC[i][24] ? 64'd2 : 64'd1);
         // R4 MSB-first bit stream
         check("R4", "bit count", 64'(nbits - b_bits), 64'd16);
         check("R4", "wire data", {48'd0, cap[15:0]}, {48'd0, VEC[i][15:0]});
         check("R4", "mosi stable while sclk high", 64'(mode_err - b_mode), 64'd0);
         // R5 half period
         check("R5", "half-period violations", 64'(half_err - b_half), 64'd0);
         // R6 gated clock
         check("R6", "sclk while deselected", 64'(gate_err - b_gate), 64'd0);
         // R11 guard: one setup cycle plus 2*div per frame
         check("R11", "cycles deselected and not idle", 64'(guard_cnt - b_guard),
               64'((frames - b_frames) * (2 * d + 1)));
         // R10 sticky done flags, then cleared by read
         check("R10", "done flags set", 64'(status[2:1]), 64'd3);
         read_status();
         check("R10", "done flags cleared", 64'(status[2:1]), 64'd0);
      end

      // R1 / R9: empty rises while the word is still shifting
      div_val = 8'd4; exp_half = 4;
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'h5A;
      @(negedge clk);
      wr_en = 1'b0;
      check("R1", "sel_n before load", 64'(sel_n), 64'd1);
      @(negedge clk);
      check("R1", "sel_n after load", 64'(sel_n), 64'd0);
      check("R9", "empty while shifting", 64'(status[0]), 64'd1);
      check("R11", "idle low while selected", 64'(status[3]), 64'd0);
      wait_idle();
      read_status();

      // R7 / R8: overflow with six quick writes at a slow clock
      div_val = 8'd8; exp_half = 8;
      b_bits = nbits; b_frames = frames;
      @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         if (k == 5) check("R7", "full before 6th write", 64'(full), 64'd1);
         if (k == 3) check("R7", "not full at 3 queued", 64'(full), 64'd0);
         wr_en = 1'b1; wr_data = 8'h11 * 8'(k + 1);
         @(negedge clk);
      end
      wr_en = 1'b0;
      check("R8", "overflow set", 64'(status[4]), 64'd1);
      read_status();
      check("R8", "overflow cleared by read", 64'(status[4]), 64'd0);
      wait_idle();
      check("R7", "dropped write not sent", 64'(nbits - b_bits), 64'd40);
      check("R7", "accepted words", {24'd0, cap[39:0]}, {24'd0, 40'h1122334455});
      check("R2", "one frame for burst", 64'(frames - b_frames), 64'd1);
      check("R12", "back to rest", 64'(status), 64'h0F);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule